// File: doc/BRIEF.md
# Block-Allocated Multi-Queue Buffer

This block holds several independent first-in first-out queues inside one shared word memory. The memory is cut into equal blocks, and each queue owns a contiguous run of whole blocks that is described by a base block number and a block count. A queue whose block count is zero holds nothing. Queues that are not used are simply left at zero blocks. The write port names a target queue on every cycle and appends a word when its enable is high. The read port names a source queue and removes words when its enable is high. Both ports share one clock.

Status is reported per port, and only for the queue that port currently names. The read side works first-word-fall-through. Once a non-empty queue has been selected, its oldest word appears on the output register without any read enable, and each enabled read then moves on to the next word. When the read side lands on an empty queue, the output keeps the last word it showed. Layouts are loaded one queue at a time through a small configuration port while traffic is stopped.

Top module: `mq_fifo`

## Requirements
- R1: A cycle with `cfg_we` high loads queue `cfg_qid` with base block `cfg_base` and `cfg_nblk` blocks, giving it a capacity of `cfg_nblk` × 16 words, and empties that queue. A queue with zero blocks reports both full and empty.
- R2: A cycle with `wr_en` high and `wr_full` low appends `wr_data` to the tail of queue `wr_qid` at the rising edge.
- R3: `wr_full` is high exactly when the queue currently on `wr_qid` holds as many words as its capacity. It follows `wr_qid` within the same cycle.
- R4: A write to a full queue is dropped, and neither the stored words nor the count of any queue changes.
- R5: `rd_qid` is taken in at every rising edge. `rd_empty` is high exactly when the queue taken in at the last edge holds no words.
- R6: After a non-empty queue has been taken in as the read selection, `rd_data` shows its oldest word from that edge on, with no read enable needed.
- R7: A cycle with `rd_en` high and `rd_empty` low removes the oldest word of the selected queue, and `rd_data` shows the following word after that edge. This gives one word per cycle in order.
- R8: A read while `rd_empty` is high is ignored. `rd_data` keeps the last word it showed, including after a switch to an empty queue.
- R9: Each queue's write and read positions wrap inside its own block run, so order is kept across any number of wraps.
- R10: The two ports may name the same queue or different queues in the same cycle. A word written to the queue being read that is empty or just drained appears on `rd_data` one edge later.
- R11: After reset all queues have zero blocks: `wr_full` and `rd_empty` are high, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the layout of one queue |
| cfg_qid | input | 3 | Queue being configured |
| cfg_base | input | 4 | First block of that queue |
| cfg_nblk | input | 5 | Number of blocks, 0 to 16 |
| wr_en | input | 1 | Write enable |
| wr_qid | input | 3 | Queue selected for writing |
| wr_data | input | 16 | Word to write |
| wr_full | output | 1 | Selected write queue is full |
| rd_en | input | 1 | Read enable (advance to next word) |
| rd_qid | input | 3 | Queue selected for reading |
| rd_data | output | 16 | Output register, oldest word of read queue |
| rd_empty | output | 1 | Selected read queue is empty |

## Verification
The bench uses the default parameters: eight queues, sixteen blocks of sixteen words, and 16-bit data. The block counts are chosen as 1, 2, 0, 3, 1, 4, 1 and 4, so they use every block. At this size every queue can be filled past its capacity and drained past empty in a few hundred cycles. Long mixed traffic, with both ports sweeping all queue numbers, wraps every region several times. A model of one list per queue predicts status and output data on every cycle, including the bypass case where the read queue is refilled while it is empty.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int unsigned DEF_Q_NUM     = 8;
    localparam int unsigned DEF_BLK_NUM   = 16;
    localparam int unsigned DEF_BLK_WORDS = 16;
    localparam int unsigned DEF_DATA_W    = 16;

    // where the next output-register value comes from
    typedef enum logic [1:0] {
        HEAD_HOLD   = 2'd0,
        HEAD_BYPASS = 2'd1,
        HEAD_MEM    = 2'd2
    } head_src_e;
endpackage

// File: rtl/mq_queue_ctx.sv
module mq_queue_ctx #(
    parameter int unsigned BLK_WORDS = 16,
    parameter int unsigned BLK_W     = 4,
    parameter int unsigned NBLK_W    = 5,
    parameter int unsigned OFF_W     = 8,
    parameter int unsigned CNT_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ld,
    input  logic [BLK_W-1:0] cfg_base,
    input  logic [NBLK_W-1:0] cfg_nblk,
    input  logic             push,
    input  logic             pop,
    output logic [OFF_W-1:0] base_addr,
    output logic [CNT_W-1:0] cap,
    output logic [CNT_W-1:0] cnt,
    output logic [OFF_W-1:0] wr_off,
    output logic [OFF_W-1:0] rd_off,
    output logic [OFF_W-1:0] rd_off_adv
);
    typedef struct packed {
        logic [BLK_W-1:0] base;
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] cnt;
        logic [OFF_W-1:0] wr_off;
        logic [OFF_W-1:0] rd_off;
    } ctx_t;

    ctx_t s_d, s_q;

    function automatic logic [OFF_W-1:0] advance(input logic [OFF_W-1:0] off,
                                                 input logic [CNT_W-1:0] lim);
        if (CNT_W'(off) + CNT_W'(1) >= lim) return '0;
        return off + OFF_W'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (cfg_ld) begin
            s_d.base   = cfg_base;
            s_d.cap    = CNT_W'(cfg_nblk) * CNT_W'(BLK_WORDS);
            s_d.cnt    = '0;
            s_d.wr_off = '0;
            s_d.rd_off = '0;
        end else begin
            if (push) s_d.wr_off = advance(s_q.wr_off, s_q.cap);
            if (pop)  s_d.rd_off = advance(s_q.rd_off, s_q.cap);
            s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign base_addr  = OFF_W'(s_q.base) * OFF_W'(BLK_WORDS);
    assign cap        = s_q.cap;
    assign cnt        = s_q.cnt;
    assign wr_off     = s_q.wr_off;
    assign rd_off     = s_q.rd_off;
    assign rd_off_adv = advance(s_q.rd_off, s_q.cap);

    // count never passes the capacity of the region
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= cap);
    // the port logic never pushes into a full queue
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> cnt < cap);
    // the port logic never pops an empty queue
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt != '0);
    // both positions stay inside the allocated run
    assert_off_in_region_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap != '0) |-> (CNT_W'(wr_off) < cap && CNT_W'(rd_off) < cap));
endmodule

// File: rtl/mq_store.sv
module mq_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
    import mq_pkg::*;
#(
    parameter int unsigned Q_NUM     = DEF_Q_NUM,
    parameter int unsigned BLK_NUM   = DEF_BLK_NUM,
    parameter int unsigned BLK_WORDS = DEF_BLK_WORDS,
    parameter int unsigned DATA_W    = DEF_DATA_W,
    localparam int unsigned QID_W  = $clog2(Q_NUM),
    localparam int unsigned BLK_W  = $clog2(BLK_NUM),
    localparam int unsigned NBLK_W = $clog2(BLK_NUM + 1),
    localparam int unsigned ADDR_W = $clog2(BLK_NUM * BLK_WORDS),
    localparam int unsigned CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QID_W-1:0]  cfg_qid,
    input  logic [BLK_W-1:0]  cfg_base,
    input  logic [NBLK_W-1:0] cfg_nblk,
    input  logic              wr_en,
    input  logic [QID_W-1:0]  wr_qid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_en,
    input  logic [QID_W-1:0]  rd_qid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    typedef struct packed {
        logic [QID_W-1:0]  rd_sel;
        logic [DATA_W-1:0] rd_data;
    } port_t;

    port_t p_d, p_q;

    logic [ADDR_W-1:0] base_a [Q_NUM];
    logic [CNT_W-1:0]  cap_a  [Q_NUM];
    logic [CNT_W-1:0]  cnt_a  [Q_NUM];
    logic [ADDR_W-1:0] wro_a  [Q_NUM];
    logic [ADDR_W-1:0] rdo_a  [Q_NUM];
    logic [ADDR_W-1:0] adv_a  [Q_NUM];

    logic              push, pop;
    logic              pop_t, push_t;
    logic [CNT_W-1:0]  left_t;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] mem_rdata;
    head_src_e         head_src;

    // per-queue context: one instance per logical queue
    for (genvar gi = 0; gi < Q_NUM; gi++) begin : g_q
        logic cfg_hit, push_hit, pop_hit;
        assign cfg_hit  = cfg_we && (cfg_qid == QID_W'(gi));
        assign push_hit = push   && (wr_qid == QID_W'(gi));
        assign pop_hit  = pop    && (p_q.rd_sel == QID_W'(gi));

        mq_queue_ctx #(
            .BLK_WORDS (BLK_WORDS),
            .BLK_W     (BLK_W),
            .NBLK_W    (NBLK_W),
            .OFF_W     (ADDR_W),
            .CNT_W     (CNT_W)
        ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_ld     (cfg_hit),
            .cfg_base   (cfg_base),
            .cfg_nblk   (cfg_nblk),
            .push       (push_hit),
            .pop        (pop_hit),
            .base_addr  (base_a[gi]),
            .cap        (cap_a[gi]),
            .cnt        (cnt_a[gi]),
            .wr_off     (wro_a[gi]),
            .rd_off     (rdo_a[gi]),
            .rd_off_adv (adv_a[gi])
        );
    end

    mq_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    always_comb begin
        // write side: status of the queue named this cycle
        wr_full = (cnt_a[wr_qid] == cap_a[wr_qid]);
        push    = wr_en && !wr_full;
        waddr   = base_a[wr_qid] + wro_a[wr_qid];

        // read side: status of the queue taken in at the last edge
        rd_empty = (cnt_a[p_q.rd_sel] == '0);
        pop      = rd_en && !rd_empty;

        // the queue that will be selected after this edge
        pop_t  = pop  && (p_q.rd_sel == rd_qid);
        push_t = push && (wr_qid == rd_qid);
        left_t = cnt_a[rd_qid] - CNT_W'(pop_t);
        raddr  = base_a[rd_qid] + (pop_t ? adv_a[rd_qid] : rdo_a[rd_qid]);

        if (cfg_we && cfg_qid == rd_qid) head_src = HEAD_HOLD;
        else if (left_t != '0)           head_src = HEAD_MEM;
        else if (push_t)                 head_src = HEAD_BYPASS;
        else                             head_src = HEAD_HOLD;

        p_d        = p_q;
        p_d.rd_sel = rd_qid;
        case (head_src)
            HEAD_MEM:    p_d.rd_data = mem_rdata;
            HEAD_BYPASS: p_d.rd_data = wr_data;
            default:     p_d.rd_data = p_q.rd_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rd_data = p_q.rd_data;

    // an empty read selection keeps the previous output word
    assert_hold_on_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |-> rd_data == $past(rd_data));
endmodule

// File: tb/mq_fifo_test.sv
module mq_fifo_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_qid = '0;
    logic [3:0]  cfg_base = '0;
    logic [4:0]  cfg_nblk = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_qid = '0;
    logic [15:0] wr_data = '0;
    logic        wr_full;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_qid = 3'd2;
    logic [15:0] rd_data;
    logic        rd_empty;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int          cap_m [8];
    logic [15:0] mq [8][$];
    logic [15:0] first_w [8];
    logic [15:0] exp_data = '0;
    int          rsel = 2;
    int          seq = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mq_fifo uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_base(cfg_base), .cfg_nblk(cfg_nblk),
        .wr_en(wr_en), .wr_qid(wr_qid), .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_qid(rd_qid), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle of traffic, started and finished at a falling edge
    task automatic cycle(input int wq, input bit we, input int rq, input bit re);
        logic [15:0] wd;
        bit wacc, racc;
        wd = {3'(wq), 13'(seq)};
        seq++;
        wr_qid = 3'(wq); wr_en = we; wr_data = wd;
        rd_qid = 3'(rq); rd_en = re;
        #1;
        chk("R3 wr_full", 32'(wr_full), 32'(mq[wq].size() == cap_m[wq]));
        chk("R5 rd_empty", 32'(rd_empty), 32'(mq[rsel].size() == 0));
        wacc = we && (mq[wq].size() < cap_m[wq]);
        racc = re && (mq[rsel].size() != 0);
        @(posedge clk);
        if (racc) void'(mq[rsel].pop_front());
        if (wacc) mq[wq].push_back(wd);
        if (wacc && mq[wq].size() == 1 && first_w[wq] == '0) first_w[wq] = wd;
        rsel = rq;
        if (mq[rsel].size() != 0) exp_data = mq[rsel][0];
        @(negedge clk);
        chk("R2/R7/R10 rd_data", 32'(rd_data), 32'(exp_data));
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic load(input int q, input int base, input int nblk);
        cfg_we = 1'b1; cfg_qid = 3'(q); cfg_base = 4'(base); cfg_nblk = 5'(nblk);
        @(posedge clk);
        mq[q].delete();
        cap_m[q] = nblk * 16;
        if (mq[rsel].size() != 0) exp_data = mq[rsel][0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        if (!finished)
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int q = 0; q < 8; q++) begin cap_m[q] = 0; first_w[q] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        for (int q = 0; q < 8; q++) begin
            wr_qid = 3'(q);
            #1;
            chk("R11 wr_full after reset", 32'(wr_full), 32'd1);
        end
        chk("R11 rd_empty after reset", 32'(rd_empty), 32'd1);
        chk("R11 rd_data after reset", 32'(rd_data), 32'd0);
        @(negedge clk);

        // R1: layout using all sixteen blocks, queue 2 left at zero
        load(0, 0, 1);  load(1, 1, 2);  load(2, 0, 0);  load(3, 3, 3);
        load(4, 6, 1);  load(5, 7, 4);  load(6, 11, 1); load(7, 12, 4);
        for (int q = 0; q < 8; q++) begin
            wr_qid = 3'(q);
            #1;
            chk("R1 full after config", 32'(wr_full), 32'(q == 2));
        end
        @(negedge clk);

        // R2/R4: fill every queue past capacity, read side parked on empty queue 2
        for (int q = 0; q < 8; q++)
            for (int k = 0; k < cap_m[q] + 2; k++) cycle(q, 1, 2, 0);
        chk("R8 output unchanged while parked on empty", 32'(rd_data), 32'd0);

        // R6/R7/R8: drain each queue in order, past empty
        for (int q = 0; q < 8; q++) begin
            logic [15:0] last;
            cycle(0, 0, q, 0);
            if (cap_m[q] != 0)
                chk("R6 head shown without read", 32'(rd_data), 32'(first_w[q]));
            last = rd_data;
            for (int k = 0; k < cap_m[q] + 2; k++) begin
                if (mq[q].size() != 0) last = mq[q][0];
                cycle(0, 0, q, 1);
            end
            chk("R8 empty after drain", 32'(rd_empty), 32'd1);
            chk("R8 last word kept", 32'(rd_data), 32'(last));
        end

        // R8: switch to an empty queue keeps the last word
        begin
            logic [15:0] keep;
            keep = rd_data;
            cycle(0, 0, 2, 0);
            chk("R8 switch to empty queue holds", 32'(rd_data), 32'(keep));
        end

        // R9/R10: mixed traffic sweeping all queues on both ports
        for (int i = 0; i < 1500; i++)
            cycle((i * 3) % 8, (i % 5) != 0, (i / 7) % 8, (i % 3) != 1);

        // R10/R9: streaming through one queue on both ports at once
        for (int i = 0; i < 200; i++) cycle(5, 1, 5, i > 3);

        // R10: bypass into the queue being read while it is empty
        for (int i = 0; i < 80; i++) cycle(4, 0, 4, 1);
        cycle(4, 1, 4, 0);
        chk("R10 bypass word visible", 32'(rd_empty), 32'd0);

        // R1: reloading a queue that holds data empties it
        for (int i = 0; i < 5; i++) cycle(0, 1, 1, 0);
        load(0, 0, 1);
        cycle(0, 0, 0, 0);
        chk("R1 reload empties queue", 32'(rd_empty), 32'd1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule